// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a memory array that two ports share. It watches both ports' addresses and active-low chip selects in one clock domain. When both ports select the same word, it settles which port goes on. The port that reached that word second gets an active-low busy flag, and its write strobe is held off inside the block so that the write never reaches the array. Reads from that port are not gated. The block only qualifies the write strobes.

A mode input picks between two roles. As the arbiter (master), the block makes its own decisions and drives both busy outputs. As a follower (slave), it makes no decisions and holds its busy outputs high. A low level on the per-port busy inputs then blocks that port's writes. Every output is registered, so busy and the qualified write strobe for a given set of inputs both appear one cycle after those inputs are sampled.

Top module: `dp_collision_arb`

## Requirements
- R1: When either chip select is high, or the two addresses differ, both busy outputs are high one cycle later.
- R2: In master mode, if one port is already selecting an address and the other port newly selects the same address, the newcomer's busy output goes low one cycle later and the other port's busy stays high.
- R3: The two busy outputs are never low in the same cycle.
- R4: If both ports newly select the same address in the same cycle, the right port gets busy low and the left port goes on. A port "newly selects" when its chip select goes low, or when its address changes while the chip select stays low.
- R5: A port whose busy is low (master mode) has its qualified write strobe held high in that same cycle, whatever its raw write strobe is.
- R6: A port that is not blocked has a qualified write strobe equal to (raw write strobe OR chip select), delayed by one cycle.
- R7: In slave mode (mode input low), both busy outputs are high. A low busy input at a sampling edge forces that port's qualified write strobe high one cycle later.
- R8: Busy stays low while the winning port keeps its chip select low and its address unchanged. It returns high one cycle after the winner lifts its chip select or moves to a different address.
- R9: After synchronous reset, both busy outputs and both qualified write strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| master_mode | input | 1 | 1 = arbiter drives busy, 0 = follower uses busy inputs |
| l_addr | input | ADDR_W | Left port address |
| l_ce_n | input | 1 | Left chip select, active low |
| l_we_n | input | 1 | Left raw write strobe, active low |
| l_busy_in_n | input | 1 | Left busy input (slave mode), active low |
| r_addr | input | ADDR_W | Right port address |
| r_ce_n | input | 1 | Right chip select, active low |
| r_we_n | input | 1 | Right raw write strobe, active low |
| r_busy_in_n | input | 1 | Right busy input (slave mode), active low |
| l_busy_n | output | 1 | Left busy output, active low |
| r_busy_n | output | 1 | Right busy output, active low |
| l_we_q_n | output | 1 | Left qualified write strobe, active low |
| r_we_q_n | output | 1 | Right qualified write strobe, active low |

## Verification
The hardest situation to reach is a winner that moves away and comes back. For example, the loser holds a colliding address, the winner leaves it, and then the loser or the winner reselects it. Whether busy flips sides then depends on which port counts as newly arriving. Purely random addresses over 14 bits almost never collide. The stimulus therefore draws addresses from a small pool that includes the top word, keeps chip selects mostly low, and adds directed sequences for simultaneous arrival, hold, release and re-arrival by either side.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_t;

  // Decide which port proceeds when a collision is (re)evaluated.
  // The port that did not just arrive was there first and wins;
  // a tie goes to the left port.
  function automatic owner_t pick_owner(input logic l_new, input logic r_new);
    if (l_new && !r_new) return OWN_RIGHT;
    return OWN_LEFT;
  endfunction

endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  output logic              active,
  output logic              arrive
);
  logic              was_active;
  logic [ADDR_W-1:0] last_addr;

  assign active = !ce_n;
  assign arrive = active && (!was_active || (last_addr != addr));

  always_ff @(posedge clk) begin
    if (rst) begin
      was_active <= 1'b0;
      last_addr  <= '0;
    end else begin
      was_active <= active;
      last_addr  <= addr;
    end
  end
endmodule

// File: rtl/dpa_collision_fsm.sv
module dpa_collision_fsm
  import dpa_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic master_mode,
  input  logic l_active,
  input  logic r_active,
  input  logic l_arrive,
  input  logic r_arrive,
  input  logic addr_eq,
  output logic l_block_nxt,
  output logic r_block_nxt,
  output logic l_busy_n,
  output logic r_busy_n
);
  owner_t owner_q, owner_d;
  logic   collide;

  assign collide = l_active && r_active && addr_eq;

  always_comb begin
    owner_d = owner_q;
    if (!master_mode || !collide) begin
      owner_d = OWN_NONE;
    end else begin
      unique case (owner_q)
        OWN_NONE:  owner_d = pick_owner(l_arrive, r_arrive);
        OWN_LEFT:  if (l_arrive) owner_d = pick_owner(l_arrive, r_arrive);
        OWN_RIGHT: if (r_arrive) owner_d = pick_owner(l_arrive, r_arrive);
        default:   owner_d = OWN_NONE;
      endcase
    end
  end

  assign l_block_nxt = (owner_d == OWN_RIGHT);
  assign r_block_nxt = (owner_d == OWN_LEFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q  <= OWN_NONE;
      l_busy_n <= 1'b1;
      r_busy_n <= 1'b1;
    end else begin
      owner_q  <= owner_d;
      l_busy_n <= !l_block_nxt;
      r_busy_n <= !r_block_nxt;
    end
  end
endmodule

// File: rtl/dpa_write_gate.sv
module dpa_write_gate (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic we_n,
  input  logic block,
  output logic we_q_n
);
  always_ff @(posedge clk) begin
    if (rst) we_q_n <= 1'b1;
    else     we_q_n <= we_n || ce_n || block;
  end
endmodule

// File: rtl/dp_collision_arb.sv
module dp_collision_arb #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_ce_n,
  input  logic              l_we_n,
  input  logic              l_busy_in_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_ce_n,
  input  logic              r_we_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_we_q_n,
  output logic              r_we_q_n
);
  localparam int NPORT = 2;

  logic [ADDR_W-1:0] p_addr  [NPORT];
  logic              p_ce_n  [NPORT];
  logic              p_we_n  [NPORT];
  logic              p_bin_n [NPORT];
  logic              p_act   [NPORT];
  logic              p_arr   [NPORT];
  logic              p_bnxt  [NPORT];
  logic              p_blk   [NPORT];
  logic              p_weq_n [NPORT];

  assign p_addr[0]  = l_addr;  assign p_addr[1]  = r_addr;
  assign p_ce_n[0]  = l_ce_n;  assign p_ce_n[1]  = r_ce_n;
  assign p_we_n[0]  = l_we_n;  assign p_we_n[1]  = r_we_n;
  assign p_bin_n[0] = l_busy_in_n; assign p_bin_n[1] = r_busy_in_n;

  dpa_collision_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .master_mode (master_mode),
    .l_active    (p_act[0]),
    .r_active    (p_act[1]),
    .l_arrive    (p_arr[0]),
    .r_arrive    (p_arr[1]),
    .addr_eq     (l_addr == r_addr),
    .l_block_nxt (p_bnxt[0]),
    .r_block_nxt (p_bnxt[1]),
    .l_busy_n    (l_busy_n),
    .r_busy_n    (r_busy_n)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    dpa_port_track #(.ADDR_W(ADDR_W)) u_track (
      .clk    (clk),
      .rst    (rst),
      .addr   (p_addr[g]),
      .ce_n   (p_ce_n[g]),
      .active (p_act[g]),
      .arrive (p_arr[g])
    );

    assign p_blk[g] = master_mode ? p_bnxt[g] : !p_bin_n[g];

    dpa_write_gate u_gate (
      .clk    (clk),
      .rst    (rst),
      .ce_n   (p_ce_n[g]),
      .we_n   (p_we_n[g]),
      .block  (p_blk[g]),
      .we_q_n (p_weq_n[g])
    );
  end

  assign l_we_q_n = p_weq_n[0];
  assign r_we_q_n = p_weq_n[1];
endmodule

// File: rtl/dp_collision_arb_chk.sv
module dp_collision_arb_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              master_mode,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_ce_n,
  input logic              l_busy_in_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_ce_n,
  input logic              r_busy_in_n,
  input logic              l_busy_n,
  input logic              r_busy_n,
  input logic              l_we_q_n,
  input logic              r_we_q_n
);
  AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (rst)
    !(!l_busy_n && !r_busy_n)); // R3

  AST_NO_MATCH_IDLE: assert property (@(posedge clk) disable iff (rst)
    (l_ce_n || r_ce_n || (l_addr != r_addr)) |=> (l_busy_n && r_busy_n)); // R1

  AST_LEFT_BUSY_GATES: assert property (@(posedge clk) disable iff (rst)
    !l_busy_n |-> l_we_q_n); // R5

  AST_RIGHT_BUSY_GATES: assert property (@(posedge clk) disable iff (rst)
    !r_busy_n |-> r_we_q_n); // R5

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !master_mode |=> (l_busy_n && r_busy_n)); // R7

  AST_SLAVE_IN_GATES: assert property (@(posedge clk) disable iff (rst)
    (!master_mode && !l_busy_in_n) |=> l_we_q_n); // R7

  AST_HOLD_LEFT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (master_mode && !l_busy_n && !l_ce_n && !r_ce_n && (l_addr == r_addr)
     && $stable(r_addr) && $stable(r_ce_n) && $stable(l_addr) && $stable(l_ce_n))
    |=> !l_busy_n); // R8
endmodule

bind dp_collision_arb dp_collision_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .master_mode (master_mode),
  .l_addr      (l_addr),
  .l_ce_n      (l_ce_n),
  .l_busy_in_n (l_busy_in_n),
  .r_addr      (r_addr),
  .r_ce_n      (r_ce_n),
  .r_busy_in_n (r_busy_in_n),
  .l_busy_n    (l_busy_n),
  .r_busy_n    (r_busy_n),
  .l_we_q_n    (l_we_q_n),
  .r_we_q_n    (r_we_q_n)
);

// File: tb/dp_collision_arb_tb_top.sv
module dp_collision_arb_tb_top;
  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst;
  logic          master_mode;
  logic [AW-1:0] l_addr, r_addr;
  logic          l_ce_n, r_ce_n, l_we_n, r_we_n, l_busy_in_n, r_busy_in_n;
  logic          l_busy_n, r_busy_n, l_we_q_n, r_we_q_n;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  // reference model state
  logic          m_lwas, m_rwas;
  logic [AW-1:0] m_llast, m_rlast;
  int            m_own;           // 0 none, 1 left wins, 2 right wins
  logic          e_lb, e_rb, e_lw, e_rw;

  always #5 clk = ~clk;

  dp_collision_arb #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .master_mode(master_mode),
    .l_addr(l_addr), .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_busy_in_n(l_busy_in_n),
    .r_addr(r_addr), .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n), .l_we_q_n(l_we_q_n), .r_we_q_n(r_we_q_n)
  );

  function automatic int winner_of(input logic ln, input logic rn);
    return (ln && !rn) ? 2 : 1;
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_lwas = 0; m_rwas = 0; m_llast = '0; m_rlast = '0; m_own = 0;
    e_lb = 1; e_rb = 1; e_lw = 1; e_rw = 1;
  endtask

  // Called with inputs applied, before the sampling edge.
  task automatic model_step();
    logic la, ra, ln, rn, hit;
    la  = !l_ce_n; ra = !r_ce_n;
    ln  = la && (!m_lwas || m_llast != l_addr);
    rn  = ra && (!m_rwas || m_rlast != r_addr);
    hit = la && ra && (l_addr == r_addr);
    if (!master_mode || !hit)           m_own = 0;
    else if (m_own == 0)                m_own = winner_of(ln, rn);
    else if (m_own == 1 && ln)          m_own = winner_of(ln, rn);
    else if (m_own == 2 && rn)          m_own = winner_of(ln, rn);
    e_lb = !(m_own == 2);
    e_rb = !(m_own == 1);
    e_lw = l_we_n | l_ce_n | (master_mode ? (m_own == 2) : !l_busy_in_n);
    e_rw = r_we_n | r_ce_n | (master_mode ? (m_own == 1) : !r_busy_in_n);
    m_lwas = la; m_rwas = ra; m_llast = l_addr; m_rlast = r_addr;
  endtask

  // Drive at negedge, step the model, let the edge pass, check at the next negedge.
  task automatic cycle(input string tag_b, input string tag_w,
                       input logic mm, input logic [AW-1:0] la, input logic lc, input logic lw, input logic lbi,
                       input logic [AW-1:0] ra, input logic rc, input logic rw, input logic rbi);
    master_mode = mm;
    l_addr = la; l_ce_n = lc; l_we_n = lw; l_busy_in_n = lbi;
    r_addr = ra; r_ce_n = rc; r_we_n = rw; r_busy_in_n = rbi;
    model_step();
    @(negedge clk);
    check(tag_b, "l_busy_n", l_busy_n, e_lb);
    check(tag_b, "r_busy_n", r_busy_n, e_rb);
    check(tag_w, "l_we_q_n", l_we_q_n, e_lw);
    check(tag_w, "r_we_q_n", r_we_q_n, e_rw);
  endtask

  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  initial begin
    rst = 1; master_mode = 1;
    l_addr = '0; r_addr = '0; l_ce_n = 1; r_ce_n = 1; l_we_n = 1; r_we_n = 1;
    l_busy_in_n = 1; r_busy_in_n = 1;
    model_reset();
    repeat (3) @(negedge clk);
    check("R9", "l_busy_n", l_busy_n, 1'b1);
    check("R9", "r_busy_n", r_busy_n, 1'b1);
    check("R9", "l_we_q_n", l_we_q_n, 1'b1);
    check("R9", "r_we_q_n", r_we_q_n, 1'b1);
    rst = 0;

    // R1: different addresses, both selected and writing
    cycle("R1", "R6", 1, 14'h0010, 0, 0, 1, 14'h0011, 0, 0, 1);
    // R2: left stays, right newly joins the same word -> right busy, right write blocked (R5)
    cycle("R1", "R6", 1, 14'h0020, 0, 0, 1, 14'h0030, 1, 1, 1);
    cycle("R2", "R5", 1, 14'h0020, 0, 0, 1, 14'h0020, 0, 0, 1);
    if (r_busy_n !== 1'b0) begin n_run++; n_fail++; $display("FAIL R2 r_busy_n actual=%b expected=0", r_busy_n); end
    else n_run++;
    // R8: hold while winner stays
    cycle("R8", "R5", 1, 14'h0020, 0, 0, 1, 14'h0020, 0, 0, 1);
    cycle("R8", "R6", 1, 14'h0020, 0, 1, 1, 14'h0020, 0, 0, 1);
    // R8: winner lifts select -> release next cycle
    cycle("R8", "R6", 1, 14'h0020, 1, 1, 1, 14'h0020, 0, 0, 1);
    // R2 other side: right sits, left joins at the top word
    cycle("R1", "R6", 1, 14'h0000, 1, 1, 1, TOP, 0, 1, 1);
    cycle("R2", "R5", 1, TOP, 0, 0, 1, TOP, 0, 0, 1);
    if (l_busy_n !== 1'b0) begin n_run++; n_fail++; $display("FAIL R2 l_busy_n actual=%b expected=0", l_busy_n); end
    else n_run++;
    // R8: winner (right) moves away -> release
    cycle("R8", "R6", 1, TOP, 0, 0, 1, 14'h0001, 0, 0, 1);
    // R4: both arrive together -> right busy
    cycle("R1", "R6", 1, 14'h0000, 1, 1, 1, 14'h0000, 1, 1, 1);
    cycle("R4", "R5", 1, 14'h0005, 0, 0, 1, 14'h0005, 0, 0, 1);
    if (r_busy_n !== 1'b0 || l_busy_n !== 1'b1) begin n_run++; n_fail++;
      $display("FAIL R4 l/r busy actual=%b%b expected=10", l_busy_n, r_busy_n); end
    else n_run++;
    // R8: winner re-arrives elsewhere and back -> loser was there first, flips
    cycle("R8", "R6", 1, 14'h0006, 0, 1, 1, 14'h0005, 0, 0, 1);
    cycle("R2", "R5", 1, 14'h0005, 0, 0, 1, 14'h0005, 0, 0, 1);
    // R7: slave mode, busy inputs gate writes, busy outputs high
    cycle("R7", "R7", 0, 14'h0007, 0, 0, 0, 14'h0007, 0, 0, 1);
    cycle("R7", "R7", 0, 14'h0007, 0, 0, 1, 14'h0007, 0, 0, 0);
    cycle("R7", "R6", 0, 14'h0007, 0, 0, 1, 14'h0007, 0, 0, 1);

    // constrained random
    void'($urandom(32'd4711));
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] pool [4];
      logic mm;
      pool[0] = 14'h0000; pool[1] = 14'h0001; pool[2] = TOP; pool[3] = 14'h1555;
      mm = ($urandom % 8) != 0;
      cycle(mm ? "R2" : "R7", "R5",
            mm,
            pool[$urandom % 4], ($urandom % 4) == 0, $urandom % 2, ($urandom % 4) != 0,
            pool[$urandom % 4], ($urandom % 4) == 0, $urandom % 2, ($urandom % 4) != 0);
      check("R3", "both busy", !(!l_busy_n && !r_busy_n), 1'b1);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule